// File: doc/BRIEF.md
# Sub-word Load/Store Alignment Unit

This block sits between a processor core's memory stage and a word-addressed data RAM whose writes are masked per byte. For stores it steers the low byte, low halfword or full word of the source register onto the RAM byte lanes and raises only the matching byte enables. For loads it takes the word the RAM returns, picks out the addressed byte or halfword, and extends it to 32 bits with zeros or with its sign, as the access code asks.

The access width and signedness come from the three-bit access code that the core decodes from the instruction. The unit is purely combinational. An access that is misaligned, or whose code names no supported width, is not trapped. The unit drops it: the RAM write enable, every byte enable and the register write-back enable all stay low, and the drop flag is raised. The core can then retire the instruction with no side effect.

Top module: `subword_lsu`

## Requirements
- R1: The RAM word address equals the byte address shifted right by two, for every input.
- R2: An accepted byte store (code 000 or 100) raises RAM write enable with the single byte enable bit 1<<addr[1:0], and the write data is the source byte replicated in all four lanes.
- R3: An accepted halfword store (code 001 or 101, addr[0]=0) raises write enable with byte enables 0011 when addr[1]=0 and 1100 when addr[1]=1, and the write data is the source low halfword replicated in both halves.
- R4: An accepted word store (code 010, addr[1:0]=00) raises write enable with byte enables 1111 and passes the source word unchanged.
- R5: A load with code 000 returns bits [8*addr[1:0]+7 : 8*addr[1:0]] of the RAM word sign-extended, and code 001 returns bits [16*addr[1]+15 : 16*addr[1]] sign-extended.
- R6: A load with code 100 or 101 returns the same byte or halfword zero-extended, and code 010 returns the whole RAM word.
- R7: A halfword access with addr[0]=1 or a word access with addr[1:0] not 00 is dropped: drop flag high, RAM write enable low, byte enables 0000, register write enable low.
- R8: An access with code 011, 110 or 111 is dropped in the same way as in R7 at any address.
- R9: An accepted load raises register write enable with RAM write enable low and byte enables 0000. With neither load nor store requested, every enable and the drop flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_addr | input | ADDR_W | Byte address of the access |
| i_code | input | 3 | Access width and signedness code |
| i_is_load | input | 1 | Load requested this cycle |
| i_is_store | input | 1 | Store requested this cycle |
| i_store_data | input | 32 | Source register value for stores |
| i_ram_rdata | input | 32 | Word read from the RAM at o_ram_addr |
| o_ram_addr | output | ADDR_W-2 | RAM word address |
| o_ram_we | output | 1 | RAM write enable |
| o_ram_be | output | 4 | RAM byte enables, bit n for bits [8n+7:8n] |
| o_ram_wdata | output | 32 | Lane-steered store data |
| o_load_data | output | 32 | Extended load result |
| o_reg_we | output | 1 | Register write-back enable for loads |
| o_drop | output | 1 | Access was suppressed |

## Verification
The embedded assertions take for granted that the core never raises load and store together, since a write enable with a load pending would otherwise look like a misrouted access. They also assume the RAM read word is stable while the address is. The bench keeps to both: each scenario task drives exactly one of the two request bits or neither. It moves the address and code between clock edges, and the bench's RAM returns its word combinationally from that address.

// File: rtl/subword_lsu_pkg.sv
package subword_lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;

   typedef struct packed {
      acc_size_e size;
      logic      sext;
   } acc_kind_t;

   function automatic acc_kind_t decode_code(input logic [2:0] code);
      acc_kind_t k;
      case (code)
         3'b000:  k = '{size: SZ_BYTE, sext: 1'b1};
         3'b001:  k = '{size: SZ_HALF, sext: 1'b1};
         3'b010:  k = '{size: SZ_WORD, sext: 1'b0};
         3'b100:  k = '{size: SZ_BYTE, sext: 1'b0};
         3'b101:  k = '{size: SZ_HALF, sext: 1'b0};
         default: k = '{size: SZ_NONE, sext: 1'b0};
      endcase
      return k;
   endfunction

endpackage

// File: rtl/subword_lsu_decode.sv
module subword_lsu_decode
   import subword_lsu_pkg::*;
(
   input  logic [2:0] i_code,
   input  logic [1:0] i_offset,
   output acc_kind_t  o_kind,
   output logic       o_bad
);
   logic misaligned;

   always_comb begin
      o_kind = decode_code(i_code);
      case (o_kind.size)
         SZ_HALF: misaligned = i_offset[0];
         SZ_WORD: misaligned = |i_offset;
         default: misaligned = 1'b0;
      endcase
      o_bad = misaligned | (o_kind.size == SZ_NONE);
   end

   // R7: a word access off a word boundary is never judged good
   always_comb begin
      if (o_kind.size == SZ_WORD && i_offset != 2'b00)
         a_r7_word_offset: assert (o_bad) else $error("word access at offset accepted");
   end
endmodule

// File: rtl/subword_lsu_store.sv
module subword_lsu_store
   import subword_lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  acc_size_e             i_size,
   input  logic [1:0]            i_offset,
   input  logic                  i_enable,
   input  logic [DATA_W-1:0]     i_data,
   output logic [LANES-1:0]      o_be,
   output logic [DATA_W-1:0]     o_wdata
);
   localparam int HALF_W = DATA_W / 2;

   always_comb begin
      case (i_size)
         SZ_BYTE: o_wdata = {LANES{i_data[7:0]}};
         SZ_HALF: o_wdata = {2{i_data[HALF_W-1:0]}};
         default: o_wdata = i_data;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [1:0] LANE_ID = 2'(g);
      always_comb begin
         case (i_size)
            SZ_BYTE: o_be[g] = i_enable && (i_offset == LANE_ID);
            SZ_HALF: o_be[g] = i_enable && (i_offset[1] == LANE_ID[1]);
            SZ_WORD: o_be[g] = i_enable;
            default: o_be[g] = 1'b0;
         endcase
      end
   end

   // R2 R3 R4: lane count matches the access width when enabled
   always_comb begin
      if (i_enable && i_size == SZ_BYTE)
         a_r2_one_lane: assert ($countones(o_be) == 1) else $error("byte store lane count");
      if (i_enable && i_size == SZ_HALF)
         a_r3_two_lanes: assert ($countones(o_be) == 2) else $error("half store lane count");
      if (i_enable && i_size == SZ_WORD)
         a_r4_all_lanes: assert (&o_be) else $error("word store lane count");
   end
endmodule

// File: rtl/subword_lsu_load.sv
module subword_lsu_load
   import subword_lsu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_kind_t          i_kind,
   input  logic [1:0]         i_offset,
   input  logic [DATA_W-1:0]  i_rdata,
   output logic [DATA_W-1:0]  o_data
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] byte_word;
   logic [DATA_W-1:0] half_word;
   logic [7:0]        sel_byte;
   logic [HALF_W-1:0] sel_half;

   always_comb begin
      byte_word = i_rdata >> {i_offset, 3'b000};
      half_word = i_rdata >> {i_offset[1], 4'b0000};
      sel_byte  = byte_word[7:0];
      sel_half  = half_word[HALF_W-1:0];
      case (i_kind.size)
         SZ_BYTE: o_data = {{(DATA_W-8){i_kind.sext & sel_byte[7]}}, sel_byte};
         SZ_HALF: o_data = {{(DATA_W-HALF_W){i_kind.sext & sel_half[HALF_W-1]}}, sel_half};
         default: o_data = i_rdata;
      endcase
   end

   // R5 R6: the upper bits follow the extension kind
   always_comb begin
      if (i_kind.size == SZ_BYTE && !i_kind.sext)
         a_r6_zero_byte: assert (o_data[DATA_W-1:8] == '0) else $error("byte not zero-extended");
      if (i_kind.size == SZ_BYTE && i_kind.sext)
         a_r5_sign_byte: assert (o_data[DATA_W-1:7] == '0 || &o_data[DATA_W-1:7])
            else $error("byte not sign-extended");
   end
endmodule

// File: rtl/subword_lsu.sv
module subword_lsu
   import subword_lsu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int RAM_AW = ADDR_W - 2,
   localparam int LANES  = DATA_W / 8
) (
   input  logic [ADDR_W-1:0]  i_addr,
   input  logic [2:0]         i_code,
   input  logic               i_is_load,
   input  logic               i_is_store,
   input  logic [DATA_W-1:0]  i_store_data,
   input  logic [DATA_W-1:0]  i_ram_rdata,
   output logic [RAM_AW-1:0]  o_ram_addr,
   output logic               o_ram_we,
   output logic [LANES-1:0]   o_ram_be,
   output logic [DATA_W-1:0]  o_ram_wdata,
   output logic [DATA_W-1:0]  o_load_data,
   output logic               o_reg_we,
   output logic               o_drop
);
   initial begin
      assert (DATA_W == 32) else $error("DATA_W must be 32");
      assert (ADDR_W >= 3) else $error("ADDR_W too small");
   end

   acc_kind_t  kind;
   logic       bad;
   logic [1:0] offset;
   logic       store_ok;

   assign offset     = i_addr[1:0];
   assign o_ram_addr = i_addr[ADDR_W-1:2];
   assign store_ok   = i_is_store & ~bad;
   assign o_ram_we   = store_ok;
   assign o_reg_we   = i_is_load & ~bad;
   assign o_drop     = (i_is_load | i_is_store) & bad;

   subword_lsu_decode u_decode (
      .i_code   (i_code),
      .i_offset (offset),
      .o_kind   (kind),
      .o_bad    (bad)
   );

   subword_lsu_store #(.DATA_W(DATA_W)) u_store (
      .i_size   (kind.size),
      .i_offset (offset),
      .i_enable (store_ok),
      .i_data   (i_store_data),
      .o_be     (o_ram_be),
      .o_wdata  (o_ram_wdata)
   );

   subword_lsu_load #(.DATA_W(DATA_W)) u_load (
      .i_kind   (kind),
      .i_offset (offset),
      .i_rdata  (i_ram_rdata),
      .o_data   (o_load_data)
   );

   always_comb begin
      // R7 R8: a dropped access leaves no side effect
      if (o_drop)
         a_r7_no_effect: assert (!o_ram_we && o_ram_be == '0 && !o_reg_we)
            else $error("dropped access has side effect");
      // R9: byte enables only accompany a store write
      if (!o_ram_we)
         a_r9_be_idle: assert (o_ram_be == '0) else $error("byte enables without write");
      // R9: write-back only for a requested load
      if (o_reg_we)
         a_r9_load_only: assert (i_is_load && !o_drop) else $error("write-back without load");
   end
endmodule

// File: tb/subword_lsu_bench.sv
module subword_lsu_bench;
   logic        clk = 1'b0;
   logic [31:0] addr;
   logic [2:0]  code;
   logic        is_load, is_store;
   logic [31:0] sdata, rdata;
   logic [29:0] ram_addr;
   logic        ram_we, reg_we, drop;
   logic [3:0]  be;
   logic [31:0] wdata, ldata;
   logic [31:0] ram [16];
   int          total = 0;
   int          bad   = 0;
   bit          done  = 0;

   always #2 clk = ~clk;

   subword_lsu u_subword_lsu (
      .i_addr(addr), .i_code(code), .i_is_load(is_load), .i_is_store(is_store),
      .i_store_data(sdata), .i_ram_rdata(rdata), .o_ram_addr(ram_addr),
      .o_ram_we(ram_we), .o_ram_be(be), .o_ram_wdata(wdata),
      .o_load_data(ldata), .o_reg_we(reg_we), .o_drop(drop));

   assign rdata = ram[ram_addr[3:0]];

   always @(posedge clk)
      if (ram_we)
         for (int b = 0; b < 4; b++)
            if (be[b]) ram[ram_addr[3:0]][8*b +: 8] <= wdata[8*b +: 8];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] a, input logic [2:0] c,
                        input logic ld, input logic st, input logic [31:0] d);
      @(negedge clk);
      addr = a; code = c; is_load = ld; is_store = st; sdata = d;
      #1;
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      is_load = 0; is_store = 0;
   endtask

   task automatic t_reset_idle();
      drive(32'h0000_0013, 3'b000, 0, 0, 32'hFFFF_FFFF);
      chk("R9 idle enables", {29'd0, ram_we, reg_we, drop}, 32'd0);
      chk("R9 idle be", {28'd0, be}, 32'd0);
      chk("R1 word address", {2'b00, ram_addr}, 32'h0000_0004);
   endtask

   task automatic t_byte_stores();
      for (int o = 0; o < 4; o++) begin
         drive(32'h20 + o, 3'b000, 0, 1, 32'h1234_56A0 + o);
         chk("R2 byte be", {28'd0, be}, 32'(1 << o));
         chk("R2 byte data", wdata, {4{8'hA0 + 8'(o)}});
         chk("R2 byte we", {31'd0, ram_we}, 32'd1);
      end
      idle_inputs();
      drive(32'h20, 3'b010, 1, 0, 0);
      chk("R2 ram image", ldata, 32'hA3A2_A1A0);
   endtask

   task automatic t_half_word_stores();
      drive(32'h30, 3'b010, 0, 1, 32'hDEAD_BEEF);
      chk("R4 word be", {28'd0, be}, 32'hF);
      chk("R4 word data", wdata, 32'hDEAD_BEEF);
      drive(32'h32, 3'b101, 0, 1, 32'h0000_1357);
      chk("R3 upper half be", {28'd0, be}, 32'hC);
      chk("R3 half data", wdata, 32'h1357_1357);
      drive(32'h34, 3'b001, 0, 1, 32'hFFFF_8642);
      chk("R3 lower half be", {28'd0, be}, 32'h3);
      idle_inputs();
      drive(32'h30, 3'b010, 1, 0, 0);
      chk("R4 ram after half", ldata, 32'h1357_BEEF);
   endtask

   task automatic t_loads();
      ram[5] = 32'h80F1_7F82;
      drive(32'h14, 3'b000, 1, 0, 0);
      chk("R5 lb lane0", ldata, 32'hFFFF_FF82);
      chk("R9 load we", {29'd0, ram_we, reg_we, drop}, 32'd2);
      chk("R9 load be", {28'd0, be}, 32'd0);
      drive(32'h15, 3'b000, 1, 0, 0);
      chk("R5 lb lane1", ldata, 32'h0000_007F);
      drive(32'h16, 3'b100, 1, 0, 0);
      chk("R6 lbu lane2", ldata, 32'h0000_00F1);
      drive(32'h17, 3'b000, 1, 0, 0);
      chk("R5 lb lane3", ldata, 32'hFFFF_FF80);
      drive(32'h16, 3'b001, 1, 0, 0);
      chk("R5 lh upper", ldata, 32'hFFFF_80F1);
      drive(32'h14, 3'b001, 1, 0, 0);
      chk("R5 lh lower", ldata, 32'h0000_7F82);
      drive(32'h16, 3'b101, 1, 0, 0);
      chk("R6 lhu upper", ldata, 32'h0000_80F1);
      drive(32'h14, 3'b010, 1, 0, 0);
      chk("R6 lw", ldata, 32'h80F1_7F82);
   endtask

   task automatic t_misaligned();
      ram[2] = 32'h0BAD_F00D;
      drive(32'h09, 3'b001, 0, 1, 32'h1111_2222);
      chk("R7 sh odd", {28'd0, be, 1'b0, ram_we, drop}, 32'd1);
      drive(32'h0A, 3'b010, 0, 1, 32'h3333_4444);
      chk("R7 sw off2", {28'd0, be, 1'b0, ram_we, drop}, 32'd1);
      drive(32'h0B, 3'b101, 1, 0, 0);
      chk("R7 lhu odd", {30'd0, reg_we, drop}, 32'd1);
      drive(32'h09, 3'b010, 1, 0, 0);
      chk("R7 lw off1", {30'd0, reg_we, drop}, 32'd1);
      drive(32'h0B, 3'b000, 0, 1, 32'h55);
      chk("R7 sb never misaligned", {31'd0, drop}, 32'd0);
      idle_inputs();
      drive(32'h08, 3'b010, 1, 0, 0);
      chk("R7 ram untouched", ldata, 32'h55AD_F00D);
   endtask

   task automatic t_bad_code();
      ram[3] = 32'hCAFE_0001;
      drive(32'h0C, 3'b011, 0, 1, 32'hFFFF_FFFF);
      chk("R8 code 011 store", {28'd0, be, 1'b0, ram_we, drop}, 32'd1);
      drive(32'h0C, 3'b110, 1, 0, 0);
      chk("R8 code 110 load", {30'd0, reg_we, drop}, 32'd1);
      drive(32'h0C, 3'b111, 0, 1, 32'hFFFF_FFFF);
      chk("R8 code 111 store", {30'd0, ram_we, drop}, 32'd1);
      idle_inputs();
      drive(32'h0C, 3'b010, 1, 0, 0);
      chk("R8 ram untouched", ldata, 32'hCAFE_0001);
      drive(32'hFFFF_FFFC, 3'b010, 0, 0, 0);
      chk("R1 top address", {2'b00, ram_addr}, 32'h3FFF_FFFF);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) ram[i] = '0;
      addr = 0; code = 0; is_load = 0; is_store = 0; sdata = 0;
      t_reset_idle();
      t_byte_stores();
      t_half_word_stores();
      t_loads();
      t_misaligned();
      t_bad_code();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule